// File: doc/BRIEF.md
# Status register and write-permit unit for a serial memory

This block keeps the status byte of a small serial memory and decides, cycle by cycle, whether a store may go ahead. A command controller decodes the serial stream and hands it pulses: an enable opcode received, a disable opcode received, some other opcode received, chip select released, a byte loaded for the array at a given address, and the commit of a status write or of an array write. The block answers with the status byte for read-back, a permit for the byte address currently offered, a permit for status writes, a keep strobe for each loaded byte that may be stored, and a pulse that starts the internal write cycle.

Three conditions have to agree before anything is stored. A write-enable latch must be armed. The latch is armed only when chip select is released right after a complete enable opcode. The target must lie outside the upper part of the array selected by a two-bit block field. For status writes, a protect-enable bit in the register and an active-low protect pin must not both be active. The latch drops after every successful store, so each store needs a fresh enable. The protect-enable bit and the block field stand in for nonvolatile cells and are kept in ordinary registers.

Top module: `sr_guard`

## Requirements
- R1: `status` reads bit 7 = protect-enable, bits 6:4 = 0, bits 3:2 = block field, bit 1 = write-enable latch, bit 0 = the `busy` input. All state is zero after reset.
- R2: With a 10-bit address, block field 2'b00 protects nothing, 2'b01 protects 0x300 to 0x3FF, 2'b10 protects 0x200 to 0x3FF, and 2'b11 protects 0x000 to 0x3FF. `arr_wr_ok` is low for a protected `byte_addr`.
- R3: The latch is set by a `cs_rise` pulse only when `op_wren` came earlier and no `op_other` or `op_wrdi` came in between. It reads set from the cycle after `cs_rise`.
- R4: The latch is cleared by reset, by `op_wrdi`, by an accepted status write and by an accepted array write, in the cycle after the event.
- R5: While the latch is clear, `arr_wr_ok`, `sr_wr_ok`, `byte_keep` and `cyc_start` stay low.
- R6: When bit 7 is set and `wp_n` is 0, `sr_wr_ok` is low and status commits are rejected. Array addresses outside the protected range stay writable. When bit 7 is clear, `wp_n` has no effect.
- R7: `op_wren` and `op_wrdi` act whatever the values of bit 7, the block field, `wp_n` and `busy`.
- R8: An accepted status commit pulses `cyc_start` in the same cycle. From the next cycle, bits 7, 3 and 2 come from `sr_data` bits 7, 3 and 2. The other data bits are dropped.
- R9: A rejected commit gives no `cyc_start` and leaves the latch, bit 7 and the block field unchanged.
- R10: `byte_keep` is high only for a `byte_stb` whose address is permitted. An array commit is accepted only if at least one byte was kept since the last opcode pulse.
- R11: While `busy` is 1, both permits are low and commits are rejected. A change on `wp_n` during that time leaves `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_wren | input | 1 | Pulse: enable opcode fully received |
| op_wrdi | input | 1 | Pulse: disable opcode fully received |
| op_other | input | 1 | Pulse: any other opcode received |
| cs_rise | input | 1 | Pulse: chip select released |
| sr_commit | input | 1 | Pulse: status write sequence complete |
| sr_data | input | 8 | Data byte of the status write |
| byte_stb | input | 1 | Pulse: an array data byte is loaded |
| byte_addr | input | ADDR_W | Address of the byte being loaded or checked |
| arr_commit | input | 1 | Pulse: array write sequence complete |
| wp_n | input | 1 | Active-low protect pin |
| busy | input | 1 | Internal write cycle in progress |
| status | output | 8 | Status byte for read-back |
| arr_wr_ok | output | 1 | `byte_addr` may be written now |
| sr_wr_ok | output | 1 | Status register may be written now |
| byte_keep | output | 1 | The strobed byte is kept |
| cyc_start | output | 1 | Start of an internal write cycle |

## Verification
The bench goes after the arming rule. An enable opcode followed by another opcode before chip select is released must leave the latch clear; a design that arms on the opcode itself would then accept a write it should refuse. It probes the exact range edges 0x1FF/0x200 and 0x2FF/0x300, where a wrong fraction decode shifts the protected range by a quarter of the array. It also checks that the protect pin blocks status writes only when the enable bit is set and never blocks the array. Rejected commits, page writes whose bytes were all dropped, and pin changes while busy are all checked. A design that clears the latch on a rejected commit, or that lets the pin alter state during a cycle, shows up as a wrong status byte.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_PEN  = 7;
  localparam int BIT_BHI  = 3;
  localparam int BIT_BLO  = 2;
  localparam int BIT_WEL  = 1;
  localparam int BIT_BUSY = 0;

  // R2: the block field selects the upper 0, 1/4, 1/2 or whole array.
  // region is the top two address bits; hit when region >= 4 - 2^(bp-1).
  function automatic logic blk_hit(input logic [1:0] bp, input logic [1:0] region);
    logic [2:0] lo;
    if (bp == 2'b00) return 1'b0;
    lo = 3'd4 - (3'd1 << (bp - 2'd1));
    return ({1'b0, region} >= lo);
  endfunction

  // R1: status byte packing, unused bits zero
  function automatic logic [STAT_W-1:0] pack_status(input logic pen, input logic [1:0] bp,
                                                    input logic wel, input logic busy);
    logic [STAT_W-1:0] s;
    s = '0;
    s[BIT_PEN]  = pen;
    s[BIT_BHI]  = bp[1];
    s[BIT_BLO]  = bp[0];
    s[BIT_WEL]  = wel;
    s[BIT_BUSY] = busy;
    return s;
  endfunction
endpackage

// File: rtl/sr_wel_ctrl.sv
module sr_wel_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic op_wren,
  input  logic op_wrdi,
  input  logic op_other,
  input  logic cs_rise,
  input  logic store_ok,
  output logic wel,
  output logic armed_pend
);
  logic set_evt, clr_evt;

  // R3: arm only when chip select closes a complete enable opcode
  assign set_evt = cs_rise & armed_pend;
  // R4: disable opcode or any accepted store clears the latch
  assign clr_evt = op_wrdi | store_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_pend <= 1'b0;
    end else if (op_wren) begin
      armed_pend <= 1'b1;
    end else if (op_other | op_wrdi | cs_rise) begin
      armed_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (clr_evt) begin
      wel <= 1'b0;
    end else if (set_evt) begin
      wel <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_nv_bits.sv
module sr_nv_bits
  import sr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STAT_W-1:0] din,
  output logic              pen,
  output logic [1:0]        bp
);
  // R8: only the protect-enable and block bits are taken from the data byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen <= 1'b0;
      bp  <= 2'b00;
    end else if (load) begin
      pen <= din[BIT_PEN];
      bp  <= {din[BIT_BHI], din[BIT_BLO]};
    end
  end
endmodule

// File: rtl/sr_permit.sv
module sr_permit
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              wel,
  input  logic              busy,
  input  logic              pen,
  input  logic [1:0]        bp,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              arr_ok,
  output logic              sr_ok
);
  localparam int TOP = ADDR_W - 1;
  logic [1:0] region;
  logic       in_blk, pin_lock;

  assign region   = addr[TOP -: 2];
  assign in_blk   = blk_hit(bp, region);            // R2
  assign pin_lock = pen & ~wp_n;                    // R6
  assign arr_ok   = wel & ~busy & ~in_blk;          // R5, R11
  assign sr_ok    = wel & ~busy & ~pin_lock;        // R5, R6, R11
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_wren,
  input  logic              op_wrdi,
  input  logic              op_other,
  input  logic              cs_rise,
  input  logic              sr_commit,
  input  logic [7:0]        sr_data,
  input  logic              byte_stb,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              arr_commit,
  input  logic              wp_n,
  input  logic              busy,
  output logic [7:0]        status,
  output logic              arr_wr_ok,
  output logic              sr_wr_ok,
  output logic              byte_keep,
  output logic              cyc_start
);
  logic       wel, armed_pend, pen, kept_any;
  logic [1:0] bp;
  logic       sr_accept, arr_accept, store_ok, any_op;

  sr_wel_ctrl u_wel (
    .clk(clk), .rst_n(rst_n), .op_wren(op_wren), .op_wrdi(op_wrdi),
    .op_other(op_other), .cs_rise(cs_rise), .store_ok(store_ok),
    .wel(wel), .armed_pend(armed_pend)
  );

  sr_nv_bits u_nv (
    .clk(clk), .rst_n(rst_n), .load(sr_accept), .din(sr_data),
    .pen(pen), .bp(bp)
  );

  sr_permit #(.ADDR_W(ADDR_W)) u_perm (
    .wel(wel), .busy(busy), .pen(pen), .bp(bp), .wp_n(wp_n),
    .addr(byte_addr), .arr_ok(arr_wr_ok), .sr_ok(sr_wr_ok)
  );

  // R10: bytes dropped one by one; a page with no kept byte starts nothing
  assign byte_keep = byte_stb & arr_wr_ok;
  assign any_op    = op_wren | op_wrdi | op_other;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kept_any <= 1'b0;
    end else if (any_op | arr_commit | sr_commit) begin
      kept_any <= 1'b0;
    end else if (byte_keep) begin
      kept_any <= 1'b1;
    end
  end

  // R8, R9: the commit is judged once, at the cycle it arrives
  assign sr_accept  = sr_commit & sr_wr_ok;
  assign arr_accept = arr_commit & kept_any & wel & ~busy;
  assign store_ok   = sr_accept | arr_accept;
  assign cyc_start  = store_ok;

  assign status = pack_status(pen, bp, wel, busy);  // R1
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_rise,
  input logic       wp_n,
  input logic       busy,
  input logic [7:0] status,
  input logic       arr_wr_ok,
  input logic       sr_wr_ok,
  input logic       byte_keep,
  input logic       cyc_start
);
  a_r3_arm_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cs_rise));

  a_r4_latch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !status[1]);

  a_r5_need_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> status[1]);

  a_r6_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wp_n) |-> !sr_wr_ok);

  a_r9_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable({status[7], status[3:2]}));

  a_r2_full_block: assert property (@(posedge clk) disable iff (!rst_n)
    byte_keep |-> (status[3:2] != 2'b11));

  a_r11_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sr_wr_ok && !arr_wr_ok && !cyc_start));
endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .wp_n(wp_n), .busy(busy),
  .status(status), .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok),
  .byte_keep(byte_keep), .cyc_start(cyc_start)
);

// File: tb/sr_guard_tb.sv
module sr_guard_tb;
  localparam int AW = 10;
  localparam int S_STAT = 0, S_AOK = 1, S_SOK = 2, S_KEEP = 3, S_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_wren = 0, op_wrdi = 0, op_other = 0, cs_rise = 0;
  logic sr_commit = 0, byte_stb = 0, arr_commit = 0, wp_n = 1, busy = 0;
  logic [7:0] sr_data = 8'h00;
  logic [AW-1:0] byte_addr = '0;
  logic [7:0] status;
  logic arr_wr_ok, sr_wr_ok, byte_keep, cyc_start;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {string req; int sel; logic [7:0] exp;} item_t;
  item_t q[$];

  always #5 clk = ~clk;

  sr_guard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_wren(op_wren), .op_wrdi(op_wrdi),
    .op_other(op_other), .cs_rise(cs_rise), .sr_commit(sr_commit),
    .sr_data(sr_data), .byte_stb(byte_stb), .byte_addr(byte_addr),
    .arr_commit(arr_commit), .wp_n(wp_n), .busy(busy), .status(status),
    .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok), .byte_keep(byte_keep),
    .cyc_start(cyc_start)
  );

  function automatic logic [7:0] probe(int sel);
    case (sel)
      S_STAT:  return status;
      S_AOK:   return {7'b0, arr_wr_ok};
      S_SOK:   return {7'b0, sr_wr_ok};
      S_KEEP:  return {7'b0, byte_keep};
      default: return {7'b0, cyc_start};
    endcase
  endfunction

  // monitor: pops expected items and compares mid-cycle
  always @(negedge clk) begin
    item_t it;
    logic [7:0] got;
    while (q.size() > 0) begin
      it = q.pop_front();
      got = probe(it.sel);
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
      end
    end
  end

  task automatic expect_v(string req, int sel, logic [7:0] v);
    item_t it;
    it.req = req; it.sel = sel; it.exp = v;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    op_wren = 0; op_wrdi = 0; op_other = 0; cs_rise = 0;
    sr_commit = 0; byte_stb = 0; arr_commit = 0;
  endtask

  task automatic arm();
    op_wren = 1; tick();
    cs_rise = 1; tick();
  endtask

  task automatic chk_addr(string req, logic [AW-1:0] a, logic ok);
    byte_addr = a; #1;
    expect_v(req, S_AOK, {7'b0, ok});
    tick();
  endtask

  task automatic sr_write(string req, logic [7:0] d, logic start);
    sr_data = d; sr_commit = 1;
    expect_v(req, S_CYC, {7'b0, start});
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1, R4, R5 reset state
    expect_v("R1 reset status", S_STAT, 8'h00);
    expect_v("R5 no array permit", S_AOK, 8'h00);
    expect_v("R5 no status permit", S_SOK, 8'h00);
    tick();
    // R5 byte and commit without latch
    byte_addr = 10'h010; byte_stb = 1;
    expect_v("R5 byte dropped", S_KEEP, 8'h00); tick();
    arr_commit = 1; expect_v("R5 commit rejected", S_CYC, 8'h00); tick();
    // R3 opcode in between cancels arming
    op_wren = 1; tick(); op_other = 1; tick(); cs_rise = 1; tick();
    expect_v("R3 cancelled arm", S_STAT, 8'h00); tick();
    op_wren = 1; tick(); op_wrdi = 1; tick(); cs_rise = 1; tick();
    expect_v("R3 cancelled by disable", S_STAT, 8'h00); tick();
    // R3 proper arm
    arm(); expect_v("R3 armed", S_STAT, 8'h02); tick();
    // R4 disable opcode
    op_wrdi = 1; tick(); expect_v("R4 disable clears", S_STAT, 8'h00); tick();
    // R8 status write takes only bits 7,3,2
    arm(); sr_write("R8 start pulse", 8'hFF, 1'b1);
    expect_v("R8 bits loaded, R4 latch cleared", S_STAT, 8'h8C); tick();
    // R7 arm with everything protected and pin active
    wp_n = 0; arm();
    expect_v("R7 arm under protection", S_STAT, 8'h8E);
    expect_v("R6 pin lock", S_SOK, 8'h00); tick();
    sr_write("R9 rejected no start", 8'h00, 1'b0);
    expect_v("R9 state kept", S_STAT, 8'h8E); tick();
    chk_addr("R2 bp11 0x000", 10'h000, 1'b0);
    // R6 pin high releases lock
    wp_n = 1; #1; expect_v("R6 pin released", S_SOK, 8'h01); tick();
    sr_write("R8 accept", 8'h84, 1'b1);
    expect_v("R8 new field", S_STAT, 8'h84); tick();
    wp_n = 0; arm(); expect_v("R7 arm again", S_STAT, 8'h86); tick();
    chk_addr("R2 bp01 0x2FF", 10'h2FF, 1'b1);
    chk_addr("R2 bp01 0x300", 10'h300, 1'b0);
    chk_addr("R2 bp01 0x3FF", 10'h3FF, 1'b0);
    chk_addr("R6 array open under pin lock", 10'h000, 1'b1);
    // R10 all bytes dropped => no cycle
    op_other = 1; tick();
    byte_addr = 10'h300; byte_stb = 1; #1;
    expect_v("R10 protected byte dropped", S_KEEP, 8'h00); tick();
    arr_commit = 1; expect_v("R10 empty page rejected", S_CYC, 8'h00); tick();
    expect_v("R9 latch kept", S_STAT, 8'h86); tick();
    op_other = 1; tick();
    byte_addr = 10'h3FF; byte_stb = 1; #1;
    expect_v("R10 drop 0x3FF", S_KEEP, 8'h00); tick();
    byte_addr = 10'h2FF; byte_stb = 1; #1;
    expect_v("R10 keep 0x2FF", S_KEEP, 8'h01); tick();
    arr_commit = 1; expect_v("R10 page accepted", S_CYC, 8'h01); tick();
    expect_v("R4 array write clears latch", S_STAT, 8'h84); tick();
    // R11 busy
    busy = 1; #1; expect_v("R1 busy bit", S_STAT, 8'h85); tick();
    arm(); expect_v("R7 arm while busy", S_STAT, 8'h87);
    expect_v("R11 no status permit", S_SOK, 8'h00);
    expect_v("R11 no array permit", S_AOK, 8'h00); tick();
    wp_n = 1; tick(); wp_n = 0; tick();
    expect_v("R11 pin toggle no effect", S_STAT, 8'h87); tick();
    wp_n = 1; sr_write("R11 commit rejected", 8'h00, 1'b0);
    busy = 0; #1; expect_v("R11 state after busy", S_STAT, 8'h86); tick();
    // bp10 with protect-enable clear
    sr_write("R8 load bp10", 8'h08, 1'b1);
    expect_v("R8 bp10 loaded", S_STAT, 8'h08); tick();
    arm(); wp_n = 0; #1;
    expect_v("R6 pin ignored when enable clear", S_SOK, 8'h01); tick();
    chk_addr("R2 bp10 0x1FF", 10'h1FF, 1'b1);
    chk_addr("R2 bp10 0x200", 10'h200, 1'b0);
    sr_write("R8 clear field", 8'h70, 1'b1);
    expect_v("R8 unused bits dropped", S_STAT, 8'h00); tick();
    arm(); chk_addr("R2 bp00 0x3FF", 10'h3FF, 1'b1);
    // R10 kept flag cleared by opcode
    byte_stb = 1; #1; expect_v("R10 keep", S_KEEP, 8'h01); tick();
    op_other = 1; tick();
    arr_commit = 1; expect_v("R10 kept flag cleared by opcode", S_CYC, 8'h00); tick();
    expect_v("R9 latch held", S_STAT, 8'h02); tick();
    op_wrdi = 1; tick(); expect_v("R4 final disable", S_STAT, 8'h00); tick();
    tick();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL all watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule